// File: doc/BRIEF.md
# Dual-Mode Pulse Width Modulator

This block drives one PWM output from a count-source tick. One setting word and a mode bit select between two ways of building the waveform. In wide mode the whole word is the high time, counted in source ticks, within a fixed period of 2^16−1 ticks. In split mode the word has two bytes. The low byte `m` divides the tick by `m+1` to form a coarse unit. The high byte `n` gives the high time in those units, within a period of 255 units.

Every period starts with the output high, and the output falls once the high time has run out. The mode bit and the setting word are captured when the channel is enabled and again at each period boundary. A write made in the middle of a period therefore never cuts a pulse short. At each boundary the block raises a one-cycle interrupt, unless the period that just ended had a zero duty. A zero duty keeps the output low and produces no interrupt. A low enable stops the channel and clears its counters.

Top module: `pwm_dual_gen`

## Requirements
- R1: While reset is applied, and after it with `en_i` low, `pwm_o` and `irq_o` are 0.
- R2: With `split_i`=0 (wide mode), each period lasts exactly 65535 ticks of `tick_i`.
- R3: In wide mode, `pwm_o` is high for exactly S ticks per period, where S is the whole setting word (legal range 0000–FFFE).
- R4: With `split_i`=1 (split mode), each period lasts 255·(m+1) ticks, where m = `setting_i[7:0]` (range 00–FF).
- R5: In split mode, `pwm_o` is high for n·(m+1) ticks per period, where n = `setting_i[15:8]` (range 00–FE).
- R6: In each period with a nonzero duty, `pwm_o` is high in the first cycle of the period. It falls once and does not rise again before the next period.
- R7: `split_i` and `setting_i` are captured on the clock edge that starts the channel and on the edge that takes the last tick of a period. A change made at any other time affects only the following period.
- R8: `irq_o` is high for exactly one cycle: the first cycle of a new period. This happens only when the period that ended had a nonzero duty.
- R9: A zero duty keeps `pwm_o` low and raises no interrupt. In wide mode a zero duty is a setting word of 0000. In split mode it is a high byte of 00.
- R10: One cycle after `en_i` is sampled low, `pwm_o` and `irq_o` are 0. One cycle after `en_i` is sampled high again, a fresh period begins from a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Count-source tick, one per cycle at most |
| en_i | input | 1 | Channel run enable |
| split_i | input | 1 | Mode select: 0 wide, 1 split (prescaler byte plus duty byte) |
| setting_i | input | 16 | Duty setting word |
| pwm_o | output | 1 | PWM output level |
| irq_o | output | 1 | One-cycle end-of-period interrupt pulse |

## Verification
A tick sampled on a clock edge counts toward the state that `pwm_o` shows in the cycle before that edge. The bench reads `tick_i` and `pwm_o` together at the falling edge and counts period ticks and high ticks from them. `irq_o` appears in the first cycle after the edge that takes a period's last tick. The bench closes each measured period at that cycle, compares the counts with values computed from the setting it captured on the same edge, and opens the next period there. The response to the enable is due one cycle after the edge that samples `en_i`. Inputs change one time unit after a rising edge, and every check waits for the sampling edge and the following falling edge.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } pwm_mode_e;

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              split_i,
  input  logic [HALF_W-1:0] limit_i,
  output logic              step_o,
  output logic [HALF_W-1:0] pre_o
);

  logic [HALF_W-1:0] pre_q, pre_d;
  logic              at_lim;

  assign at_lim = (pre_q == limit_i);
  assign step_o = tick_i & (~split_i | at_lim);
  assign pre_o  = pre_q;

  always_comb begin
    pre_d = pre_q;
    if (clr_i) begin
      pre_d = '0;
    end else if (tick_i && split_i) begin
      pre_d = at_lim ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  // R5
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_i |-> (pre_q <= limit_i));

endmodule

// File: rtl/pwm_unit_cnt.sv
module pwm_unit_cnt #(
  parameter int CNT_W  = 16,
  parameter int HALF_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             split_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] TERM_WIDE  = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] TERM_SPLIT = {{(CNT_W-HALF_W){1'b0}}, {(HALF_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q, cnt_d, term;

  assign term   = split_i ? TERM_SPLIT : TERM_WIDE;
  assign wrap_o = step_i & (cnt_q == term);
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (step_i) begin
      cnt_d = (cnt_q == term) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R4
  cnt_split_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_i |-> (cnt_q <= TERM_SPLIT));

  // R2
  cnt_wide_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cnt_q));

endmodule

// File: rtl/pwm_dual_gen.sv
module pwm_dual_gen
  import pwm_dual_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             split_i,
  input  logic [CNT_W-1:0] setting_i,
  output logic             pwm_o,
  output logic             irq_o
);

  localparam int HALF_W = CNT_W / 2;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  // state
  logic             run_q, run_d;
  logic             irq_q, irq_d;
  pwm_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] val_q, val_d;

  logic              split_act, clr, cnt_tick, step, wrap, load, duty_nz;
  logic [CNT_W-1:0]  cnt, duty_eff;
  logic [HALF_W-1:0] pre;

  assign split_act = (mode_q == MODE_SPLIT);
  assign clr       = ~run_q;
  assign cnt_tick  = tick_i & run_q;
  assign load      = ~run_q | wrap;

  always_comb begin
    if (split_act) begin
      duty_eff = {{(CNT_W-HALF_W){1'b0}}, val_q[CNT_W-1:HALF_W]};
    end else begin
      duty_eff = val_q;
    end
  end
  assign duty_nz = |duty_eff;

  pwm_prescale #(.HALF_W(HALF_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr_i   (clr),
    .tick_i  (cnt_tick),
    .split_i (split_act),
    .limit_i (val_q[HALF_W-1:0]),
    .step_o  (step),
    .pre_o   (pre)
  );

  pwm_unit_cnt #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr_i   (clr),
    .step_i  (step),
    .split_i (split_act),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  // next state
  always_comb begin
    run_d  = en_i;
    irq_d  = en_i & wrap & duty_nz;
    mode_d = split_i ? MODE_SPLIT : MODE_WIDE;
    val_d  = setting_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
      mode_q <= MODE_WIDE;
      val_q  <= '0;
    end else begin
      run_q <= run_d;
      irq_q <= irq_d;
      if (load) begin
        mode_q <= mode_d;
        val_q  <= val_d;
      end
    end
  end

  assign pwm_o = run_q & (cnt < duty_eff);
  assign irq_o = irq_q;

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_q |=> !irq_q);

  // R10
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !en_i |=> (!pwm_o && !irq_o));

  // R6
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(pwm_o) |-> (cnt == '0 && pre == '0));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_q && cnt != '0) |-> ($stable(val_q) && $stable(mode_q)));

  // R9
  irq_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_q && !duty_nz && !wrap) |=> !irq_o);

endmodule

// File: tb/pwm_dual_gen_tb.sv
`timescale 1ns/1ps
module pwm_dual_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, en_i, split_i;
  logic [15:0] setting_i;
  logic        pwm_o, irq_o;

  int errors = 0;
  int checks = 0;
  int dens   = 100;
  int cycles = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pwm_dual_gen #(.CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_i),
    .split_i(split_i), .setting_i(setting_i), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  function automatic int exp_period(bit sp, logic [15:0] s);
    return sp ? 255 * (int'(s[7:0]) + 1) : 65535;
  endfunction

  function automatic int exp_high(bit sp, logic [15:0] s);
    return sp ? int'(s[15:8]) * (int'(s[7:0]) + 1) : int'(s);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // tick source
  always @(posedge clk) begin
    #1;
    tick_i = (($urandom % 100) < dens);
  end

  // what the DUT sampled on each edge
  logic        prev_en = 0, prev2_en = 0, prev_split = 0;
  logic [15:0] prev_set = 0;
  always @(posedge clk) begin
    prev2_en   <= prev_en;
    prev_en    <= en_i;
    prev_split <= split_i;
    prev_set   <= setting_i;
    cycles     <= cycles + 1;
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 195000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 195000);
      finish_run();
    end
  end

  // period monitor
  bit meas_valid = 0, prev_pwm = 0, prev_irq = 0;
  int p_cnt = 0, h_cnt = 0, rises = 0, cur_p = 0, cur_h = 0;

  always @(negedge clk) begin
    bit start;
    if (rst_n) begin
      start = prev_en && !prev2_en;
      if (!prev_en) meas_valid = 0;
      if (irq_o) begin
        check(!prev_irq, "R8", "irq width", 2, 1);
        if (meas_valid) begin
          check(cur_h != 0, "R9", "irq after zero duty", cur_h, 1);
          check(p_cnt == cur_p, (prev_split ? "R4" : "R2"), "period ticks", p_cnt, cur_p);
          check(h_cnt == cur_h, (prev_split ? "R5" : "R3"), "high ticks", h_cnt, cur_h);
          check(rises == 0, "R6", "re-rise inside period", rises, 0);
        end
      end
      if (irq_o || start) begin
        cur_p = exp_period(prev_split, prev_set);
        cur_h = exp_high(prev_split, prev_set);
        p_cnt = 0; h_cnt = 0; rises = 0;
        meas_valid = 1;
        check(pwm_o == (cur_h != 0), "R6", "level at period start", pwm_o, cur_h != 0);
      end
      if (meas_valid) begin
        if (tick_i) p_cnt++;
        if (tick_i && pwm_o) h_cnt++;
        if (pwm_o && !prev_pwm && !(irq_o || start)) rises++;
      end
      prev_pwm = pwm_o;
      prev_irq = irq_o;
    end
  end

  task automatic drive(bit en, bit sp, logic [15:0] s);
    @(posedge clk); #1;
    en_i = en; split_i = sp; setting_i = s;
  endtask

  task automatic wait_irqs(int k);
    repeat (k) begin
      @(negedge clk);
      while (!irq_o) @(negedge clk);
    end
  endtask

  task automatic quiet(int n, string req);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_o || irq_o) bad++;
    end
    check(bad == 0, req, "output or irq while quiet", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd7341));
    rst_n = 0; en_i = 0; split_i = 0; setting_i = 16'h0000; tick_i = 0;
    repeat (4) @(negedge clk);
    check(pwm_o == 0 && irq_o == 0, "R1", "outputs in reset", {pwm_o, irq_o}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (5) @(negedge clk);
    check(pwm_o == 0 && irq_o == 0, "R1", "outputs after reset", {pwm_o, irq_o}, 0);

    // split mode, smallest duty and prescaler (R4 R5 R10)
    dens = 100;
    drive(1, 1, {8'h01, 8'h00});
    wait_irqs(2);

    // mid-period write of largest legal duty (R7)
    repeat (40) @(posedge clk);
    drive(1, 1, {8'hFE, 8'h03});
    wait_irqs(2);

    // random split configurations written mid-period (R4 R5 R7)
    dens = 75;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] n, m;
      n = 8'(1 + ($urandom % 254));
      m = 8'($urandom % 4);
      wait_irqs(1);
      repeat (1 + ($urandom % 200)) @(posedge clk);
      drive(1, 1, {n, m});
      wait_irqs(2);
    end

    // enable dropped mid-period (R10)
    repeat (100) @(posedge clk);
    drive(0, 1, {8'h40, 8'h01});
    @(posedge clk);
    quiet(10, "R10");

    // split mode zero duty (R9)
    dens = 100;
    drive(1, 1, {8'h00, 8'h02});
    quiet(900, "R9");
    drive(0, 1, {8'h00, 8'h02});
    repeat (3) @(posedge clk);

    // wide mode, random duty, one full period from enable (R2 R3)
    drive(1, 0, 16'h0100 + 16'($urandom % 16'hF000));
    wait_irqs(1);
    drive(0, 0, 16'h0000);
    repeat (3) @(posedge clk);

    // wide mode zero duty over more than a period (R9)
    drive(1, 0, 16'h0000);
    quiet(65600, "R9");
    drive(0, 0, 16'h0000);
    repeat (3) @(negedge clk);
    check(pwm_o == 0 && irq_o == 0, "R10", "stopped at end", {pwm_o, irq_o}, 0);
    finish_run();
  end

endmodule